// File: doc/BRIEF.md
# Oversampled Serial Byte Receiver with Station Filtering

This block takes one asynchronous serial line that rests high and turns each frame on it into a parallel byte. The line is sampled once per pulse of a 16x oversampling enable that comes from a baud generator outside the block. A frame is a low start bit, eight data bits with the least significant bit first, an optional extra bit, and a high stop bit. Each bit is read at its midpoint. A start bit that has gone high again by its midpoint is treated as noise and discarded.

In normal mode the extra bit is an optional parity bit, even or odd. In station mode the extra bit is always present and tells an address frame (1) from a payload frame (0). Parity is not used in station mode. Address frames are compared against a programmed station number. Payload frames are passed on only after a matching address frame, and only until the next address frame arrives. A matching address frame is passed on itself and tagged, so software can see that the station has been selected.

A delivered byte is held together with a full flag. The full flag drives a level receive interrupt. Software clears the flag after it reads the byte. Framing, parity and overrun flags are sticky, and together they drive a receive-error interrupt until software clears them.

Top module: `serial_addr_rx`

## Requirements
- R1: After synchronous reset, `rx_full`, `rx_is_id`, `frame_err`, `parity_err`, `overrun`, `rx_irq` and `err_irq` are 0, and `rx_byte` is 0x00.
- R2: A frame on `rxd` is a 0 start bit, then D0..D7 (LSB first), then an optional extra bit, then a 1 stop bit. Each bit lasts 16 `os_tick` pulses and is sampled at its midpoint. A valid frame loads `rx_byte` and sets `rx_full`. `rx_irq` is high while `rx_full` is 1.
- R3: If `rxd` falls and is back to 1 at the midpoint of the start bit, no frame is received and no flag changes.
- R4: With `parity_en`=1 and `mp_mode`=0, one parity bit follows D7. The parity is even when `parity_odd`=0 and odd when `parity_odd`=1. On a mismatch `parity_err` sets and no byte is delivered.
- R5: A stop bit sampled as 0 sets `frame_err`. That frame delivers no byte and does not change the station selection.
- R6: A high `clr_full` for one cycle clears `rx_full`. A high `clr_err` for one cycle clears `frame_err`, `parity_err` and `overrun`.
- R7: If a byte is to be delivered while `rx_full` is 1, `overrun` sets and `rx_byte` and `rx_is_id` keep their old values.
- R8: With `mp_mode`=1 the frame is start, 8 data bits, the address/payload bit, then stop. `parity_en` has no effect.
- R9: With `mp_mode`=1 and no station selected, every payload frame (extra bit 0) is dropped.
- R10: An address frame (extra bit 1) whose data equals `station_id` selects the station. The frame is delivered with `rx_is_id`=1. Payload frames that follow are delivered with `rx_is_id`=0.
- R11: An address frame whose data differs from `station_id` deselects the station. Payload frames that follow are dropped.
- R12: `err_irq` is high whenever any of `frame_err`, `parity_err` or `overrun` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| os_tick | input | 1 | 16x oversampling enable |
| rxd | input | 1 | Serial line, idles high |
| parity_en | input | 1 | Parity bit present (normal mode) |
| parity_odd | input | 1 | 1 = odd parity, 0 = even parity |
| mp_mode | input | 1 | Station mode with address/payload bit |
| station_id | input | 8 | Station number compared against address frames |
| clr_full | input | 1 | Clears the full flag |
| clr_err | input | 1 | Clears the error flags |
| rx_byte | output | 8 | Last delivered byte |
| rx_is_id | output | 1 | Held byte was a matching address frame |
| rx_full | output | 1 | Byte waiting for software |
| frame_err | output | 1 | Stop bit was 0 |
| parity_err | output | 1 | Parity mismatch |
| overrun | output | 1 | Byte arrived while full |
| rx_irq | output | 1 | Receive interrupt request |
| err_irq | output | 1 | Receive-error interrupt request |

## Verification
The hardest case to reach from the ports is a change of selection in the middle of a stream. This means a matching address that selects the station, payload accepted after it, and then a non-matching address that has to shut the payload off again. A frame with a bad stop bit must leave the selection alone throughout. The bench drives whole station-mode sequences frame by frame: payload before any address, a mismatching address, a matching one, payload, then a second mismatch. It does this with `parity_en` held high, so a receiver that wrongly expects a parity bit loses bit alignment at once. A behavioural model, updated at the cycle each stop bit has to take effect, is compared against every output on every clock.

// File: rtl/serial_rx_pkg.sv
// Shared types for the oversampled serial receiver.
package serial_rx_pkg;
    localparam int DATA_W = 8;

    typedef enum logic [1:0] {RX_IDLE, RX_START, RX_BITS} rx_state_e;

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              extra;
        logic              stop_ok;
    } rx_frame_t;
endpackage

// File: rtl/rx_bit_sampler.sv
// Bit timing and deserialisation. Finds a falling edge on rxd and re-checks
// it at the middle of the start bit. It then samples each following bit at
// its midpoint, once every OS_RATE ticks. When the stop bit has been sampled
// it emits one frame, marked by a single-cycle frm_valid.
// Assumes rxd is already synchronous to clk and extra_en stays stable
// during a frame.
module rx_bit_sampler
    import serial_rx_pkg::*;
#(
    parameter int OS_RATE = 16
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      os_tick,
    input  logic      rxd,
    input  logic      extra_en,
    output logic      frm_valid,
    output rx_frame_t frm
);
    localparam int CW   = $clog2(OS_RATE);
    localparam int HALF = OS_RATE / 2;
    localparam int IW   = $clog2(DATA_W + 3);

    rx_state_e         state;
    logic [CW-1:0]     cnt;
    logic [IW-1:0]     idx;
    logic [DATA_W-1:0] shreg;
    logic              extra_bit;
    logic              has_extra;
    logic              stop_bit;

    // Frame state machine: start check, bit sampling and frame emission.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= RX_IDLE;
            cnt       <= '0;
            idx       <= '0;
            shreg     <= '0;
            extra_bit <= 1'b0;
            has_extra <= 1'b0;
            stop_bit  <= 1'b0;
            frm_valid <= 1'b0;
        end else begin
            frm_valid <= 1'b0;
            if (os_tick) begin
                case (state)
                    RX_IDLE: begin
                        if (!rxd) begin
                            state <= RX_START;
                            cnt   <= '0;
                        end
                    end
                    RX_START: begin
                        if (cnt == CW'(HALF - 1)) begin
                            if (!rxd) begin
                                state     <= RX_BITS;
                                cnt       <= '0;
                                idx       <= '0;
                                has_extra <= extra_en;
                                extra_bit <= 1'b0;
                            end else begin
                                state <= RX_IDLE;
                            end
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    RX_BITS: begin
                        if (cnt == CW'(OS_RATE - 1)) begin
                            cnt <= '0;
                            idx <= idx + 1'b1;
                            if (idx < IW'(DATA_W)) begin
                                shreg <= {rxd, shreg[DATA_W-1:1]};
                            end else if (has_extra && idx == IW'(DATA_W)) begin
                                extra_bit <= rxd;
                            end else begin
                                stop_bit  <= rxd;
                                frm_valid <= 1'b1;
                                state     <= RX_IDLE;
                            end
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    default: state <= RX_IDLE;
                endcase
            end
        end
    end

    assign frm.data    = shreg;
    assign frm.extra   = extra_bit;
    assign frm.stop_ok = stop_bit;

    // R2: a frame is reported for one cycle only.
    a_r2_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        frm_valid |=> !frm_valid);
    // R3: no frame can come straight out of the idle state.
    a_r3_idle_no_frame: assert property (@(posedge clk) disable iff (!rst_n)
        (state == RX_IDLE) |=> !frm_valid);
endmodule

// File: rtl/rx_station_filter.sv
// Frame classification. Checks the stop bit and parity and keeps track of
// whether this station is selected in station mode. Decides whether a
// completed frame is handed to the holding register. Purely combinational,
// except for the selection bit.
// Assumes the mode inputs do not change while a frame is in flight.
module rx_station_filter
    import serial_rx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frm_valid,
    input  rx_frame_t         frm,
    input  logic              mp_mode,
    input  logic              parity_en,
    input  logic              parity_odd,
    input  logic [DATA_W-1:0] station_id,
    output logic              deliver,
    output logic              deliver_id,
    output logic              frame_bad,
    output logic              parity_bad
);
    logic selected;
    logic good;
    logic id_hit;

    // Classify the completed frame and decide whether it is delivered.
    always_comb begin
        good       = frm_valid && frm.stop_ok;
        id_hit     = (frm.data == station_id);
        frame_bad  = frm_valid && !frm.stop_ok;
        parity_bad = good && !mp_mode && parity_en &&
                     ((^frm.data ^ frm.extra) != parity_odd);
        if (mp_mode) begin
            deliver    = good && (frm.extra ? id_hit : selected);
            deliver_id = frm.extra;
        end else begin
            deliver    = good && !parity_bad;
            deliver_id = 1'b0;
        end
    end

    // Selection: set or cleared by each good address frame, dropped outside station mode.
    always_ff @(posedge clk) begin
        if (!rst_n || !mp_mode) begin
            selected <= 1'b0;
        end else if (good && frm.extra) begin
            selected <= id_hit;
        end
    end

    // R9: unselected payload frames never pass.
    a_r9_unselected_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (mp_mode && !selected && frm_valid && !frm.extra) |-> !deliver);
    // R11: a mismatching address leaves the station deselected.
    a_r11_mismatch_deselects: assert property (@(posedge clk) disable iff (!rst_n)
        (mp_mode && good && frm.extra && frm.data != station_id) |=> !selected);
    // R5: a frame with a bad stop bit never changes the selection.
    a_r5_bad_stop_keeps_sel: assert property (@(posedge clk) disable iff (!rst_n)
        (mp_mode && frame_bad) |=> (selected == $past(selected)));
endmodule

// File: rtl/serial_addr_rx.sv
// Top of the serial receiver. Chains the bit sampler and the station filter,
// and holds the delivered byte together with the sticky full and error flags
// that software reads and clears.
// Assumes os_tick comes from an external baud generator at 16x the bit rate,
// and that clr_full does not coincide with a frame being delivered.
module serial_addr_rx
    import serial_rx_pkg::*;
#(
    parameter int OS_RATE = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              os_tick,
    input  logic              rxd,
    input  logic              parity_en,
    input  logic              parity_odd,
    input  logic              mp_mode,
    input  logic [DATA_W-1:0] station_id,
    input  logic              clr_full,
    input  logic              clr_err,
    output logic [DATA_W-1:0] rx_byte,
    output logic              rx_is_id,
    output logic              rx_full,
    output logic              frame_err,
    output logic              parity_err,
    output logic              overrun,
    output logic              rx_irq,
    output logic              err_irq
);
    logic      frm_valid;
    rx_frame_t frm;
    logic      deliver;
    logic      deliver_id;
    logic      frame_bad;
    logic      parity_bad;

    rx_bit_sampler #(.OS_RATE(OS_RATE)) u_sampler (
        .clk       (clk),
        .rst_n     (rst_n),
        .os_tick   (os_tick),
        .rxd       (rxd),
        .extra_en  (mp_mode | parity_en),
        .frm_valid (frm_valid),
        .frm       (frm)
    );

    rx_station_filter u_filter (
        .clk        (clk),
        .rst_n      (rst_n),
        .frm_valid  (frm_valid),
        .frm        (frm),
        .mp_mode    (mp_mode),
        .parity_en  (parity_en),
        .parity_odd (parity_odd),
        .station_id (station_id),
        .deliver    (deliver),
        .deliver_id (deliver_id),
        .frame_bad  (frame_bad),
        .parity_bad (parity_bad)
    );

    // Holding register and sticky flags, set by frames and cleared by software.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_byte    <= '0;
            rx_is_id   <= 1'b0;
            rx_full    <= 1'b0;
            frame_err  <= 1'b0;
            parity_err <= 1'b0;
            overrun    <= 1'b0;
        end else begin
            if (clr_full) rx_full <= 1'b0;
            if (clr_err) begin
                frame_err  <= 1'b0;
                parity_err <= 1'b0;
                overrun    <= 1'b0;
            end
            if (frame_bad)  frame_err  <= 1'b1;
            if (parity_bad) parity_err <= 1'b1;
            if (deliver) begin
                if (rx_full) begin
                    overrun <= 1'b1;
                end else begin
                    rx_byte  <= frm.data;
                    rx_is_id <= deliver_id;
                    rx_full  <= 1'b1;
                end
            end
        end
    end

    assign rx_irq  = rx_full;
    assign err_irq = frame_err | parity_err | overrun;

    // R6: the full flag only drops on a software clear.
    a_r6_full_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_full && !clr_full) |=> rx_full);
    // R7: a held byte is never overwritten.
    a_r7_byte_held: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_full && !clr_full) |=> (rx_byte == $past(rx_byte)));
    // R2: the full flag rises only for a delivered frame.
    a_r2_full_from_frame: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_full) |-> $past(deliver));
    // R12: any error flag requests the error interrupt.
    a_r12_err_irq: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_err || parity_err || overrun) |-> err_irq);
endmodule

// File: tb/serial_addr_rx_tb_top.sv
// Self-checking bench. A behavioural model holds the expected flag state.
// The model is updated at the cycle a stop bit takes effect and is compared
// with the outputs on every clock.
module serial_addr_rx_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       os_tick = 1'b1;
    logic       rxd = 1'b1;
    logic       parity_en = 1'b0;
    logic       parity_odd = 1'b0;
    logic       mp_mode = 1'b0;
    logic [7:0] station_id = 8'h00;
    logic       clr_full = 1'b0;
    logic       clr_err = 1'b0;
    logic [7:0] rx_byte;
    logic       rx_is_id, rx_full, frame_err, parity_err, overrun, rx_irq, err_irq;

    int checks = 0;
    int errors = 0;
    bit cmp_on = 0;
    bit finished = 0;
    string scen = "R1";

    logic [7:0] e_byte = 8'h00;
    bit e_id = 0, e_full = 0, e_fe = 0, e_pe = 0, e_ov = 0, e_sel = 0;

    serial_addr_rx dut_i (
        .clk(clk), .rst_n(rst_n), .os_tick(os_tick), .rxd(rxd),
        .parity_en(parity_en), .parity_odd(parity_odd), .mp_mode(mp_mode),
        .station_id(station_id), .clr_full(clr_full), .clr_err(clr_err),
        .rx_byte(rx_byte), .rx_is_id(rx_is_id), .rx_full(rx_full),
        .frame_err(frame_err), .parity_err(parity_err), .overrun(overrun),
        .rx_irq(rx_irq), .err_irq(err_irq)
    );

    always #2.5ns clk = ~clk;

    task automatic chk(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            if (errors < 30)
                $display("FAIL %s (%s) %s actual=%h expected=%h at %0t", req, scen, what, act, exp, $time);
        end
    endtask

    // Compare every output against the model, away from the clock edge.
    always @(negedge clk) begin
        #1ns;
        if (cmp_on) begin
            chk("R2",  "rx_full",    {7'd0, rx_full},    {7'd0, e_full});
            chk("R2",  "rx_irq",     {7'd0, rx_irq},     {7'd0, e_full});
            chk("R2",  "rx_byte",    rx_byte,            e_byte);
            chk("R10", "rx_is_id",   {7'd0, rx_is_id},   {7'd0, e_id});
            chk("R5",  "frame_err",  {7'd0, frame_err},  {7'd0, e_fe});
            chk("R4",  "parity_err", {7'd0, parity_err}, {7'd0, e_pe});
            chk("R7",  "overrun",    {7'd0, overrun},    {7'd0, e_ov});
            chk("R12", "err_irq",    {7'd0, err_irq},    {7'd0, (e_fe | e_pe | e_ov)});
        end
    end

    task automatic model_deliver(input logic [7:0] d, input bit is_id);
        if (e_full) e_ov = 1;
        else begin e_full = 1; e_byte = d; e_id = is_id; end
    endtask

    task automatic model_frame(input logic [7:0] d, input bit ex, input bit stp);
        if (!stp) begin e_fe = 1; return; end
        if (mp_mode) begin
            if (ex) begin
                e_sel = (d == station_id);
                if (e_sel) model_deliver(d, 1);
            end else if (e_sel) model_deliver(d, 0);
            return;
        end
        if (parity_en && ((^d ^ ex) != parity_odd)) begin e_pe = 1; return; end
        model_deliver(d, 0);
    endtask

    // Drive one frame bit by bit, 16 ticks per bit, starting at a negedge.
    task automatic send(input logic [7:0] d, input bit has_ex, input bit ex, input bit stp);
        bit bits[$];
        bits.push_back(1'b0);
        for (int i = 0; i < 8; i++) bits.push_back(d[i]);
        if (has_ex) bits.push_back(ex);
        for (int i = 0; i < bits.size(); i++) begin
            rxd = bits[i];
            repeat (16) @(negedge clk);
        end
        rxd = stp;
        repeat (10) @(negedge clk);
        model_frame(d, ex, stp);
        repeat (6) @(negedge clk);
        rxd = 1'b1;
        repeat (24) @(negedge clk);
    endtask

    task automatic send_norm(input logic [7:0] d);
        send(d, parity_en, (^d) ^ parity_odd, 1'b1);
    endtask

    task automatic do_clr_full();
        clr_full = 1'b1;
        @(negedge clk);
        clr_full = 1'b0;
        e_full = 0;
    endtask

    task automatic do_clr_err();
        clr_err = 1'b1;
        @(negedge clk);
        clr_err = 1'b0;
        e_fe = 0; e_pe = 0; e_ov = 0;
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1ns;
        // R1: reset values
        chk("R1", "rx_full", {7'd0, rx_full}, 8'd0);
        chk("R1", "rx_byte", rx_byte, 8'h00);
        chk("R1", "err_irq", {7'd0, err_irq}, 8'd0);
        chk("R1", "flags", {4'd0, rx_is_id, frame_err, parity_err, overrun}, 8'd0);
        @(negedge clk);
        cmp_on = 1;

        scen = "R2";
        send_norm(8'hA5); do_clr_full();
        send_norm(8'h3C); do_clr_full();
        send_norm(8'h00); do_clr_full();
        send_norm(8'hFF); do_clr_full();

        scen = "R3";            // start glitch shorter than half a bit
        rxd = 1'b0; repeat (4) @(negedge clk); rxd = 1'b1;
        repeat (30) @(negedge clk);
        send_norm(8'h81); do_clr_full();

        scen = "R7";
        send_norm(8'h11);
        send_norm(8'h22);       // overrun, 0x11 kept
        scen = "R6";
        do_clr_err(); do_clr_full();
        send_norm(8'h33); do_clr_full();

        scen = "R5";
        send(8'h6E, 1'b0, 1'b0, 1'b0);
        do_clr_err();

        scen = "R4";
        parity_en = 1'b1; parity_odd = 1'b0;
        send_norm(8'h5A); do_clr_full();
        send(8'h5B, 1'b1, 1'b0, 1'b1);    // wrong even parity
        do_clr_err();
        parity_odd = 1'b1;
        send_norm(8'h5B); do_clr_full();
        send(8'h5A, 1'b1, 1'b0, 1'b1);    // wrong odd parity
        do_clr_err();

        scen = "R8";            // station mode, parity_en left high
        mp_mode = 1'b1; station_id = 8'h42;
        @(negedge clk);
        scen = "R9";
        send(8'h10, 1'b1, 1'b0, 1'b1);
        scen = "R11";
        send(8'h33, 1'b1, 1'b1, 1'b1);
        send(8'h11, 1'b1, 1'b0, 1'b1);
        scen = "R10";
        send(8'h42, 1'b1, 1'b1, 1'b1); do_clr_full();
        send(8'h77, 1'b1, 1'b0, 1'b1); do_clr_full();
        scen = "R5";            // bad stop keeps the selection
        send(8'h42, 1'b1, 1'b1, 1'b0); do_clr_err();
        scen = "R10";
        send(8'h78, 1'b1, 1'b0, 1'b1); do_clr_full();
        scen = "R11";
        send(8'h50, 1'b1, 1'b1, 1'b1);
        send(8'h99, 1'b1, 1'b0, 1'b1);
        send(8'h9A, 1'b1, 1'b0, 1'b1);

        scen = "R2";
        mp_mode = 1'b0; parity_en = 1'b0;
        @(negedge clk); e_sel = 0;
        send_norm(8'hC3); do_clr_full();

        cmp_on = 0;
        finished = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog actual=running expected=done");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule